// File: doc/BRIEF.md
# Parallel Fixed-Packet CRC-16

This block produces a 16-bit CRC of a complete 53-byte packet in a single evaluation. The packet arrives as one 424-bit word together with a valid strobe. It does not run 53 dependent byte updates. It relies on the linearity of the CRC instead.

When every data bit is zero, the CRC is a fixed constant. Each data bit that is one toggles the result by a 16-bit pattern of its own, and that pattern does not depend on the other bits. The block ANDs every bus bit with its pattern and reduces the 424 terms through a balanced XOR tree. It then folds in the constant. The patterns and the constant are computed during elaboration by constant functions, so no table is stored in the source.

The result is registered. It appears together with a valid flag on the cycle after the packet is strobed in, and it stays on the output until the next packet arrives.

Top module: `pkt_crc16`

## Requirements
- R1: While rst_ni is low, crc_valid_o is 0 and crc_o is 16'h0000.
- R2: crc_valid_o is 1 exactly on the cycle after a cycle with valid_i high. It is 0 after every cycle with valid_i low.
- R3: The crc_o value that accompanies crc_valid_o is computed as follows. Byte k of the packet is pkt_i[8k+7:8k]. Bytes are taken in ascending order and each byte is taken LSB first. The register starts at 16'hFFFF. Each bit is shifted right through the reflected polynomial 16'h8408. The final register is inverted.
- R4: A packet of all zeros gives the same fixed constant on every evaluation, as defined by R3.
- R5: A packet with a single set bit at any position, including bits 0, 7, 8 and 423, gives the CRC defined by R3.
- R6: While valid_i is low, crc_o holds the last result, whatever pkt_i does.
- R7: Packets strobed on consecutive cycles each produce their own result on the consecutive following cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_i | input | 424 | Packet word, byte 0 in bits [7:0] |
| valid_i | input | 1 | Packet present this cycle |
| crc_o | output | 16 | CRC of the last packet presented |
| crc_valid_o | output | 1 | crc_o was updated on this cycle |

## Verification
The assertions check on every cycle the following properties:
- the valid flag follows the strobe with a one-cycle lag;
- the result holds across idle cycles;
- an all-zero packet produces the fixed constant;
- the outputs are cleared during reset.

Whether the value is the correct CRC for arbitrary data can only be shown by the bench's scenarios. The bench compares every result against a byte-wise reference model that is independent of the bit-level table. The scenarios cover single-bit packets at the byte and word edges, back-to-back random streams and an all-ones packet.

// File: rtl/pkt_crc16_pkg.sv
package pkt_crc16_pkg;
  localparam int unsigned CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  // one reflected shift step with data bit d
  function automatic crc_t crc_bit_step(crc_t c, logic d, crc_t poly);
    crc_t r;
    r = c >> 1;
    if (c[0] ^ d) r = r ^ poly;
    return r;
  endfunction

  // CRC of an all-zero message of nbits bits
  function automatic crc_t crc_zero_msg(int unsigned nbits, crc_t poly, crc_t init, crc_t xout);
    crc_t c;
    c = init;
    for (int unsigned i = 0; i < nbits; i++) c = crc_bit_step(c, 1'b0, poly);
    return c ^ xout;
  endfunction
endpackage

// File: rtl/pkt_crc_contrib.sv
module pkt_crc_contrib
  import pkt_crc16_pkg::*;
#(
  parameter int unsigned NBITS = 424,
  parameter crc_t        POLY  = 16'h8408,
  parameter crc_t        INIT  = 16'hFFFF,
  parameter crc_t        XOUT  = 16'hFFFF
) (
  input  logic [NBITS-1:0] pkt_i,
  output crc_t             leaf_o [NBITS],
  output crc_t             base_o
);
  localparam int unsigned TBL_W = NBITS * CRC_W;

  // contribution of bit j = zero-step map applied (NBITS-1-j) times to POLY
  function automatic logic [TBL_W-1:0] build_tbl();
    logic [TBL_W-1:0] t;
    crc_t c;
    t = '0;
    c = POLY;
    t[(NBITS-1)*CRC_W +: CRC_W] = c;
    for (int j = int'(NBITS) - 2; j >= 0; j--) begin
      c = crc_bit_step(c, 1'b0, POLY);
      t[j*CRC_W +: CRC_W] = c;
    end
    return t;
  endfunction

  localparam logic [TBL_W-1:0] TBL  = build_tbl();
  localparam crc_t             BASE = crc_zero_msg(NBITS, POLY, INIT, XOUT);

  for (genvar i = 0; i < NBITS; i++) begin : g_leaf
    assign leaf_o[i] = pkt_i[i] ? TBL[i*CRC_W +: CRC_W] : '0;
  end

  assign base_o = BASE;
endmodule

// File: rtl/pkt_crc_xor_tree.sv
module pkt_crc_xor_tree
  import pkt_crc16_pkg::*;
#(
  parameter int unsigned N = 424
) (
  input  crc_t leaf_i [N],
  output crc_t root_o
);
  localparam int unsigned LV = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned P  = 1 << LV;

  // heap layout: node[1] root, leaves at node[P..2P-1]
  crc_t node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_pad
    if (i < N) begin : g_in
      assign node[P+i] = leaf_i[i];
    end else begin : g_zero
      assign node[P+i] = '0;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    assign node[k] = node[2*k] ^ node[2*k+1];
  end

  assign root_o = node[1];
endmodule

// File: rtl/pkt_crc_out_stage.sv
module pkt_crc_out_stage
  import pkt_crc16_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  crc_t crc_i,
  input  logic valid_i,
  output crc_t crc_o,
  output logic valid_o
);
  if (OUT_REG) begin : g_reg
    crc_t crc_q;
    logic vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        crc_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) crc_q <= crc_i;
      end
    end
    assign crc_o   = crc_q;
    assign valid_o = vld_q;
  end else begin : g_comb
    assign crc_o   = crc_i;
    assign valid_o = valid_i;
  end
endmodule

// File: rtl/pkt_crc16.sv
module pkt_crc16
  import pkt_crc16_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 53,
  parameter crc_t        POLY      = 16'h8408,
  parameter crc_t        INIT      = 16'hFFFF,
  parameter crc_t        XOUT      = 16'hFFFF,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned PKT_BITS = PKT_BYTES * 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PKT_BITS-1:0] pkt_i,
  input  logic                valid_i,
  output logic [CRC_W-1:0]    crc_o,
  output logic                crc_valid_o
);
  crc_t leaf [PKT_BITS];
  crc_t base;
  crc_t sum;
  crc_t crc_comb;

  pkt_crc_contrib #(
    .NBITS(PKT_BITS), .POLY(POLY), .INIT(INIT), .XOUT(XOUT)
  ) u_contrib (
    .pkt_i  (pkt_i),
    .leaf_o (leaf),
    .base_o (base)
  );

  pkt_crc_xor_tree #(.N(PKT_BITS)) u_tree (
    .leaf_i (leaf),
    .root_o (sum)
  );

  assign crc_comb = sum ^ base;

  pkt_crc_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .crc_i   (crc_comb),
    .valid_i (valid_i),
    .crc_o   (crc_o),
    .valid_o (crc_valid_o)
  );
endmodule

// File: rtl/pkt_crc16_chk.sv
module pkt_crc16_chk
  import pkt_crc16_pkg::*;
#(
  parameter int unsigned PKT_BITS = 424,
  parameter crc_t        POLY     = 16'h8408,
  parameter crc_t        INIT     = 16'hFFFF,
  parameter crc_t        XOUT     = 16'hFFFF,
  parameter bit          OUT_REG  = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [PKT_BITS-1:0] pkt_i,
  input logic                valid_i,
  input logic [CRC_W-1:0]    crc_o,
  input logic                crc_valid_o
);
  localparam crc_t ZERO_CRC = crc_zero_msg(PKT_BITS, POLY, INIT, XOUT);

  if (OUT_REG) begin : g_chk
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        a_r1_reset_clear: assert (!crc_valid_o && crc_o == '0);
      end
    end

    a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> crc_valid_o);

    a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !crc_valid_o);

    a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(crc_o));

    a_r4_zero_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && pkt_i == '0) |=> (crc_o == ZERO_CRC));
  end
endmodule

bind pkt_crc16 pkt_crc16_chk #(
  .PKT_BITS(PKT_BITS), .POLY(POLY), .INIT(INIT), .XOUT(XOUT), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_i       (pkt_i),
  .valid_i     (valid_i),
  .crc_o       (crc_o),
  .crc_valid_o (crc_valid_o)
);

// File: tb/sim_pkt_crc16.sv
`timescale 1ns/1ps
module sim_pkt_crc16;
  localparam int NB = 53;
  localparam int NBITS = NB * 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NBITS-1:0] pkt_i = '0;
  logic             valid_i = 1'b0;
  logic [15:0]      crc_o;
  logic             crc_valid_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_crc;
  bit          have_last = 1'b0;

  always #2 clk_i = ~clk_i;

  pkt_crc16 u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_i(pkt_i), .valid_i(valid_i),
    .crc_o(crc_o), .crc_valid_o(crc_valid_o)
  );

  // byte-wise reference: reflected 0x8408, init FFFF, final inversion
  function automatic logic [15:0] ref_crc(logic [NBITS-1:0] p);
    logic [15:0] c;
    logic [7:0]  t;
    c = 16'hFFFF;
    for (int b = 0; b < NB; b++) begin
      t = c[7:0] ^ p[8*b +: 8];
      t = t ^ (t << 4);
      c = (c >> 8) ^ ({8'h00, t} << 8) ^ ({8'h00, t} << 3) ^ ({8'h00, t} >> 4);
    end
    return ~c;
  endfunction

  function automatic logic [NBITS-1:0] rnd_pkt();
    logic [NBITS-1:0] p;
    p = '0;
    for (int w = 0; w < 14; w++) p = {p[NBITS-33:0], 32'($urandom())};
    return p;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [NBITS-1:0] p, string tag);
    @(negedge clk_i);
    pkt_i   = p;
    valid_i = 1'b1;
    exp_q.push_back(ref_crc(p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      pkt_i   = rnd_pkt();  // must be ignored (R6)
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni) begin
        if (crc_valid_o) begin
          if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R2 actual=valid expected=no result pending");
          end else begin
            logic [15:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, crc_o, e);
            last_crc  = e;
            have_last = 1'b1;
          end
        end else if (have_last) begin
          check("R6 hold", crc_o, last_crc);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 crc", crc_o, 16'h0000);
    check("R1 valid", {15'd0, crc_valid_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    check("R2 idle", {15'd0, crc_valid_o}, 16'h0000);

    send('0, "R4 zero");
    idle(3);
    send('0, "R4 zero again");
    idle(2);

    send(NBITS'(1) << 0,   "R5 bit0");
    send(NBITS'(1) << 7,   "R5 bit7");
    send(NBITS'(1) << 8,   "R5 bit8");
    send(NBITS'(1) << 200, "R5 bit200");
    send(NBITS'(1) << 423, "R5 bit423");
    idle(3);

    for (int i = 0; i < 40; i++) send(rnd_pkt(), "R3 R7 random");
    idle(4);
    send('1, "R3 all ones");
    send(rnd_pkt(), "R3 random");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R7 actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule